// File: doc/BRIEF.md
# Fault-Tolerant Sequencing Controller

This block is a small control state machine that runs a fixed wait-then-read sequence for a neighbouring datapath. After a start request it waits a programmable number of cycles, issues a read phase, and then takes a decision. The decision either parks the machine until a FIFO reports readiness or returns it straight to idle. The machine never looks at a wide bus. A separate wait counter gives it one terminal-count pulse. A separate watchdog gives it one timeout pulse. The machine in turn drives one counter-clear bit back to the counter and one restart bit to the watchdog. Every output comes from a flip-flop.

All eight encodings of the 3-bit state register have a role. Five are working states. The other three form a start-up sweep that the machine walks through after every reset before it reaches idle. If an upset drops the machine into a sweep encoding during operation, it finishes the sweep, lands in idle and raises a one-cycle fault flag. A watchdog limits the time spent in any waiting state. If an awaited handshake never arrives, or came too early to be seen, the machine goes back to idle and flags a fault.

Top module: `seq_guard_ctrl`

## Requirements
- R1: While `rst_ni` is low, and during the sweep after it, the outputs are ready=0, read=0, fifo-wait=0, counter-clear=1 and fault=0. Pulling `rst_ni` low takes effect without a clock edge. After `rst_ni` rises at a falling clock edge, `ready_o` rises on the 5th rising edge: two edges for reset synchronisation and three sweep states.
- R2: If the state is upset into a sweep encoding while the machine runs, it continues the sweep to idle. `fault_o` is high for exactly the first cycle after leaving the upset encoding, and `ready_o` returns one edge after that when the upset landed on the last sweep encoding but one.
- R3: In idle (`ready_o`=1) the machine stays put until `start_i` is high at a clock edge. On that edge it enters the wait state, which drops `ready_o` and `cnt_clr_o`.
- R4: Suppose start is taken at edge E0 and the counter's terminal count is TERM_CNT (default 128). The counter pulses for one cycle after edge E0+TERM_CNT. At edge E0+TERM_CNT+1 the machine raises `rd_o` and `cnt_clr_o` together.
- R5: In the read state, `rd_done_i` high at an edge moves the machine to the decision state, where `ready_o`, `rd_o` and `fifo_wait_o` are all low.
- R6: In the decision state, the machine moves only when `qual_i` is high. With `qual_i` high, `sel_fifo_i` moves it to FIFO-wait (`fifo_wait_o`=1) and `sel_idle_i` returns it to idle. `sel_fifo_i` wins when both are high.
- R7: In FIFO-wait, `fifo_ok_i` high returns the machine to idle.
- R8: If a waiting state gets no handshake, the machine leaves it at the (WD_LIMIT+2)-th edge after entry (default 1026), goes to idle, and raises `fault_o` for exactly one cycle.
- R9: When a valid handshake arrives in the same cycle as the watchdog timeout, the handshake transition is taken and `fault_o` stays low.
- R10: At most one of `ready_o`, `rd_o` and `fifo_wait_o` is high at any time.
- R11: `start_i` has no effect outside idle. In the read state, `rd_o` stays high while `start_i` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin a sequence (idle only) |
| rd_done_i | input | 1 | Read phase complete |
| qual_i | input | 1 | Qualifies the decision inputs |
| sel_fifo_i | input | 1 | Decision: go wait for the FIFO |
| sel_idle_i | input | 1 | Decision: go back to idle |
| fifo_ok_i | input | 1 | FIFO ready, ends the FIFO-wait state |
| ready_o | output | 1 | Registered: machine is idle |
| rd_o | output | 1 | Registered: read phase active |
| fifo_wait_o | output | 1 | Registered: waiting on the FIFO |
| cnt_clr_o | output | 1 | Registered: holds the wait counter cleared |
| fault_o | output | 1 | Registered one-cycle fault pulse (timeout or upset) |

## Verification
The watchdog timeout and a legitimate handshake can fall in the same cycle, and the priority between them decides whether a fault is reported. The bench drives a read and reaches the decision state. It then holds the machine there for exactly WD_LIMIT+1 edges, so the timeout pulse is present, and applies the qualified FIFO selection just before the next edge. The result is judged at the ports: `fifo_wait_o` must rise and `fault_o` must stay low.

// File: rtl/seqg_pkg.sv
package seqg_pkg;

  // Working states use the low five codes; the top three form the
  // start-up sweep so that every 3-bit value belongs to the flow.
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WAIT   = 3'd1,
    S_READ   = 3'd2,
    S_DECIDE = 3'd3,
    S_FWAIT  = 3'd4,
    S_SWP0   = 3'd5,
    S_SWP1   = 3'd6,
    S_SWP2   = 3'd7
  } state_t;

  function automatic logic is_sweep(input state_t s);
    return (s == S_SWP0) || (s == S_SWP1) || (s == S_SWP2);
  endfunction

endpackage

// File: rtl/seqg_rst_sync.sv
module seqg_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/seqg_wait_cnt.sv
module seqg_wait_cnt #(
  parameter int CNT_W    = 16,
  parameter int TERM_CNT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tc_o
);

  localparam logic [CNT_W-1:0] TC_PRE = CNT_W'(TERM_CNT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tc_q;
  logic             cnt_en;

  assign cnt_en = !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + 1'b1;
      tc_q  <= (cnt_q == TC_PRE);
    end else begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end
  end

  assign tc_o = tc_q;

  // R4: terminal count is a single-cycle pulse
  assert_tc_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q |=> !tc_q);

endmodule

// File: rtl/seqg_watchdog.sv
module seqg_watchdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic timeout_o
);

  localparam int WD_W = $clog2(LIMIT + 1);
  localparam logic [WD_W-1:0] LIM_V = WD_W'(LIMIT);
  localparam logic [WD_W-1:0] LIM_P = WD_W'(LIMIT - 1);

  logic [WD_W-1:0] cnt_q;
  logic            to_q;
  logic            run_en;

  assign run_en = !kick_i && (cnt_q != LIM_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (kick_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (run_en) begin
      cnt_q <= cnt_q + 1'b1;
      to_q  <= (cnt_q == LIM_P);
    end else begin
      to_q  <= 1'b0;
    end
  end

  assign timeout_o = to_q;

  // R8: timeout is a single-cycle pulse
  assert_timeout_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |=> !to_q);

endmodule

// File: rtl/seqg_core.sv
module seqg_core
  import seqg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_done_i,
  input  logic qual_i,
  input  logic sel_fifo_i,
  input  logic sel_idle_i,
  input  logic fifo_ok_i,
  input  logic tc_i,
  input  logic to_i,
  output logic ready_o,
  output logic rd_o,
  output logic fifo_wait_o,
  output logic cnt_clr_o,
  output logic kick_o,
  output logic fault_o
);

  state_t state_q;
  logic   sweep_q;
  logic   ready_q, rd_q, fw_q, clr_q, kick_q, fault_q;

  // Move to a target state and register the outputs that belong to it.
  task automatic go(input state_t t);
    state_q <= t;
    ready_q <= (t == S_IDLE);
    rd_q    <= (t == S_READ);
    fw_q    <= (t == S_FWAIT);
    clr_q   <= (t != S_WAIT);
    kick_q  <= (t != state_q) || (t == S_IDLE) || is_sweep(t);
  endtask

  // One clocked process owns every transition and every output.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_SWP0;
      sweep_q <= 1'b1;
      ready_q <= 1'b0;
      rd_q    <= 1'b0;
      fw_q    <= 1'b0;
      clr_q   <= 1'b1;
      kick_q  <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) go(S_WAIT);
          else         go(S_IDLE);
        end
        S_WAIT: begin
          if (tc_i) go(S_READ);
          else if (to_i) begin
            go(S_IDLE);
            fault_q <= 1'b1;
          end else go(S_WAIT);
        end
        S_READ: begin
          if (rd_done_i) go(S_DECIDE);
          else if (to_i) begin
            go(S_IDLE);
            fault_q <= 1'b1;
          end else go(S_READ);
        end
        S_DECIDE: begin
          if (qual_i && sel_fifo_i)      go(S_FWAIT);
          else if (qual_i && sel_idle_i) go(S_IDLE);
          else if (to_i) begin
            go(S_IDLE);
            fault_q <= 1'b1;
          end else go(S_DECIDE);
        end
        S_FWAIT: begin
          if (fifo_ok_i) go(S_IDLE);
          else if (to_i) begin
            go(S_IDLE);
            fault_q <= 1'b1;
          end else go(S_FWAIT);
        end
        S_SWP0, S_SWP1: begin
          go(state_t'(state_q + 3'd1));
          if (!sweep_q) fault_q <= 1'b1;
          sweep_q <= 1'b1;
        end
        S_SWP2: begin
          go(S_IDLE);
          if (!sweep_q) fault_q <= 1'b1;
          sweep_q <= 1'b0;
        end
        default: begin
          go(S_SWP0);
          fault_q <= 1'b1;
          sweep_q <= 1'b1;
        end
      endcase
    end
  end

  assign ready_o     = ready_q;
  assign rd_o        = rd_q;
  assign fifo_wait_o = fw_q;
  assign cnt_clr_o   = clr_q;
  assign kick_o      = kick_q;
  assign fault_o     = fault_q;

  // R4: terminal count in the wait state opens the read phase with the clear raised
  assert_clr_with_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && tc_i) |=> (rd_q && clr_q));

  // R6: the FIFO selection wins over the idle selection
  assert_fifo_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DECIDE && qual_i && sel_fifo_i && sel_idle_i) |=> fw_q);

  // R8: an unanswered timeout in the read state recovers to idle with a fault
  assert_timeout_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_READ && to_i && !rd_done_i) |=> (ready_q && fault_q));

  // R8 / R2: fault lasts one cycle
  assert_fault_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> !fault_q);

  // R9: a handshake coinciding with the timeout is taken without a fault
  assert_race_handshake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DECIDE && to_i && qual_i && sel_fifo_i) |=> (fw_q && !fault_q));

  // R10: status outputs are mutually exclusive
  assert_onehot_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ready_q, rd_q, fw_q}));

endmodule

// File: rtl/seq_guard_ctrl.sv
module seq_guard_ctrl #(
  parameter int CNT_W    = 16,
  parameter int TERM_CNT = 128,
  parameter int WD_LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_done_i,
  input  logic qual_i,
  input  logic sel_fifo_i,
  input  logic sel_idle_i,
  input  logic fifo_ok_i,
  output logic ready_o,
  output logic rd_o,
  output logic fifo_wait_o,
  output logic cnt_clr_o,
  output logic fault_o
);

  logic rst_n;
  logic tc, to, clr, kick;

  seqg_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  seqg_wait_cnt #(
    .CNT_W    (CNT_W),
    .TERM_CNT (TERM_CNT)
  ) u_wait_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (clr),
    .tc_o   (tc)
  );

  seqg_watchdog #(
    .LIMIT (WD_LIMIT)
  ) u_watchdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .kick_i    (kick),
    .timeout_o (to)
  );

  seqg_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .rd_done_i   (rd_done_i),
    .qual_i      (qual_i),
    .sel_fifo_i  (sel_fifo_i),
    .sel_idle_i  (sel_idle_i),
    .fifo_ok_i   (fifo_ok_i),
    .tc_i        (tc),
    .to_i        (to),
    .ready_o     (ready_o),
    .rd_o        (rd_o),
    .fifo_wait_o (fifo_wait_o),
    .cnt_clr_o   (clr),
    .kick_o      (kick),
    .fault_o     (fault_o)
  );

  assign cnt_clr_o = clr;

endmodule

// File: tb/seq_guard_ctrl_bench.sv
module seq_guard_ctrl_bench;
  import seqg_pkg::*;

  localparam int LIM  = 1024;
  localparam int TERM = 128;

  logic clk = 1'b0;
  logic rst_ni;
  logic start, rd_done, qual, sel_fifo, sel_idle, fifo_ok;
  logic ready, rd, fw, clr, fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  seq_guard_ctrl u_seq_guard_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .rd_done_i   (rd_done),
    .qual_i      (qual),
    .sel_fifo_i  (sel_fifo),
    .sel_idle_i  (sel_idle),
    .fifo_ok_i   (fifo_ok),
    .ready_o     (ready),
    .rd_o        (rd),
    .fifo_wait_o (fw),
    .cnt_clr_o   (clr),
    .fault_o     (fault)
  );

  // din = {start, rd_done, qual, sel_fifo, sel_idle, fifo_ok}
  // exp = {ready, rd, fifo_wait, cnt_clr, fault}
  typedef struct packed {
    logic [23:0] tag;
    logic [5:0]  din;
    logic [15:0] hold;
    logic [4:0]  exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{"R3",  6'b100000, 16'd1,   5'b00000},  // start taken
    '{"R4",  6'b000000, 16'd128, 5'b00000},  // still waiting at E0+128
    '{"R4",  6'b000000, 16'd1,   5'b01010},  // read + clear at E0+129
    '{"R11", 6'b100000, 16'd2,   5'b01010},  // start ignored in read
    '{"R5",  6'b010000, 16'd1,   5'b00010},  // to decision
    '{"R6",  6'b001000, 16'd3,   5'b00010},  // qual alone: stay
    '{"R6",  6'b000100, 16'd2,   5'b00010},  // select without qual: stay
    '{"R6",  6'b001110, 16'd1,   5'b00110},  // both selects: fifo wins
    '{"R7",  6'b000000, 16'd2,   5'b00110},  // fifo not ready: stay
    '{"R7",  6'b000001, 16'd1,   5'b10010},  // fifo ready: idle
    '{"R3",  6'b000000, 16'd3,   5'b10010},  // idle holds
    '{"R3",  6'b100000, 16'd1,   5'b00000},
    '{"R4",  6'b000000, 16'd128, 5'b00000},
    '{"R4",  6'b000000, 16'd1,   5'b01010},
    '{"R5",  6'b010000, 16'd1,   5'b00010},
    '{"R6",  6'b001010, 16'd1,   5'b10010}   // qual + idle select
  };

  task automatic drive(input logic [5:0] d);
    {start, rd_done, qual, sel_fifo, sel_idle, fifo_ok} = d;
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {ready, rd, fw, clr, fault};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {ready,rd,fw,clr,fault} act=%b exp=%b at %0t", req, act, exp, $time);
    end
    checks++;
    if ($countones({ready, rd, fw}) > 1) begin
      errors++;
      $display("FAIL R10: status act=%b exp=at most one set", {ready, rd, fw});
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_read();
    drive(6'b100000); edges(1);
    drive(6'b000000); edges(TERM + 1);
    chk("R4", 5'b01010);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=run not finished exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    drive(6'b000000);
    #10;
    chk("R1", 5'b00010);                 // in reset
    @(negedge clk); rst_ni = 1'b1;
    edges(4); chk("R1", 5'b00010);       // still synchronising / sweeping
    edges(1); chk("R1", 5'b10010);       // idle on the 5th edge

    // table walk
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].din);
      edges(int'(VECS[v].hold));
      chk($sformatf("%s row %0d", VECS[v].tag, v), VECS[v].exp);
    end
    drive(6'b000000);

    // R8: read withheld -> timeout recovery
    go_read();
    edges(LIM + 1); chk("R8", 5'b01010);
    edges(1);       chk("R8", 5'b10011);
    edges(1);       chk("R8", 5'b10010);

    // R9: handshake coincides with timeout
    go_read();
    drive(6'b010000); edges(1); chk("R9", 5'b00010);
    drive(6'b000000); edges(LIM + 1); chk("R9", 5'b00010);
    drive(6'b001100); edges(1); chk("R9", 5'b00110);
    drive(6'b000001); edges(1); chk("R7", 5'b10010);
    drive(6'b000000);

    // R2: upset into a sweep encoding
    edges(1);
    force u_seq_guard_ctrl.u_core.state_q = S_SWP1;
    #1 release u_seq_guard_ctrl.u_core.state_q;
    edges(1); chk("R2", 5'b00011);
    edges(1); chk("R2", 5'b10010);

    // R1: asynchronous reset in the middle of a wait
    drive(6'b100000); edges(1); drive(6'b000000); edges(5);
    chk("R3", 5'b00000);
    #1 rst_ni = 1'b0;
    #1 chk("R1", 5'b00010);
    @(negedge clk); rst_ni = 1'b1;
    edges(4); chk("R1", 5'b00010);
    edges(1); chk("R1", 5'b10010);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule